// File: doc/BRIEF.md
# Motor Driver Protection and Fault Supervisor

This block decides when the two full bridges of a motor driver may conduct. It watches an active-low sleep input, digitized over-temperature set/release flags, supply-undervoltage set/release flags, one overcurrent flag per bridge and the four direction inputs. From these it produces a single bridge-enable, a wake-ready indication and an active-low fault output meant to drive an open-drain pad.

Leaving sleep starts a settling timer of `WAKE_CYC` clock cycles, and no command is honoured until it expires. Temperature and supply faults follow their own hysteresis: each sets on its set flag and clears only on its release flag. An overcurrent on either bridge is different. It shuts both bridges off and stays latched until the sleep input is pulled low or the supply is cycled. Supply cycling is modelled by the synchronous active-low reset. When all four direction inputs are low, the bridges are idle. The block is still awake in that state, so the wake timer is not disturbed.

Top module: `mdrv_fault_sup`

## Requirements
- R1: While `rst_n` is sampled low, and at the clock edge after it, `bridge_en` = 0, `wake_ready` = 0 and `fault_n` = 1.
- R2: `wake_ready` goes to 1 at the `WAKE_CYC`-th consecutive rising edge that samples `sleep_n` high, and it stays 1 while `sleep_n` stays high. A low sample restarts the count from zero.
- R3: After an edge that samples `sleep_n` low, `wake_ready` = 0 and `bridge_en` = 0.
- R4: A single-cycle high on any bit of `oc_flag` while awake sets the overcurrent latch. After that edge `bridge_en` = 0 and `fault_n` = 0.
- R5: The overcurrent latch holds after the flag drops. Only a low sample of `sleep_n` or a reset clears it, and `fault_n` returns to 1 after that edge.
- R6: `ot_set` sampled high forces `bridge_en` = 0 and `fault_n` = 0 after the edge. The condition holds until an edge with `ot_rel` high and `ot_set` low. When both flags are high, set wins.
- R7: `uv_set` sampled high forces `bridge_en` = 0 after the edge, and it stays so until `uv_rel` is sampled high with `uv_set` low. Undervoltage alone leaves `fault_n` at 1. When both flags are high, set wins.
- R8: When `dir_in` = 4'b0000, `bridge_en` = 0 in the same cycle. The wake timer and `wake_ready` are unaffected.
- R9: `bridge_en` = 1 exactly when the block is wake-ready, no undervoltage, thermal or overcurrent condition is held, and `dir_in` is non-zero.
- R10: An `oc_flag` pulse sampled while `sleep_n` is low is ignored. After waking, `fault_n` = 1 and `bridge_en` rises with `wake_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, models supply cycling |
| sleep_n | input | 1 | Active-low sleep request |
| ot_set | input | 1 | Over-temperature trip flag |
| ot_rel | input | 1 | Temperature hysteresis release flag |
| uv_set | input | 1 | Supply undervoltage trip flag |
| uv_rel | input | 1 | Supply recovered flag |
| oc_flag | input | NUM_BRIDGE | Per-bridge overcurrent flags |
| dir_in | input | NUM_DIR | Direction inputs of both bridges |
| bridge_en | output | 1 | Bridges may conduct |
| wake_ready | output | 1 | Awake and settling delay elapsed |
| fault_n | output | 1 | Active-low thermal or overcurrent fault |

## Verification
A lost or stuck overcurrent latch appears at `fault_n` one edge after the flag pulse. It also appears after a sleep cycle, when `fault_n` fails to come back or never went low. A wake counter that is off by one shows up as `wake_ready` rising one cycle early or late, and the bench checks every cycle of the settling window. A thermal or undervoltage state with the wrong release rule, or the wrong set/release priority, shows on `bridge_en` and `fault_n` in the cycle after the flag edge.

// File: rtl/mdrv_pkg.sv
// Shared sizes and types for the motor driver fault supervisor.
// Assumes two bridges with two direction inputs each.
package mdrv_pkg;
    localparam int NUM_BRIDGE = 2;
    localparam int DIR_PER_BR = 2;
    localparam int NUM_DIR    = NUM_BRIDGE * DIR_PER_BR;

    // Held protection conditions, one bit each.
    typedef struct packed {
        logic uv;
        logic ot;
        logic oc;
    } mdrv_hold_t;
endpackage

// File: rtl/mdrv_hyst_flag.sv
// Hysteresis state from a pair of digitized set/release flags.
// The set flag wins when both are high. Assumes flags already synchronous.
module mdrv_hyst_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rel_i,
    output logic held_o
);
    // Set has priority, release only clears, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_o <= 1'b0;
        else if (set_i)  held_o <= 1'b1;
        else if (rel_i)  held_o <= 1'b0;
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o);
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !set_i) |=> !held_o);
endmodule

// File: rtl/mdrv_oc_latch.sv
// One overcurrent latch per bridge, ORed into a single shutdown.
// A one-cycle flag is enough. Sleep clears, and flags are ignored while asleep.
module mdrv_oc_latch #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          awake_i,
    input  logic [NB-1:0] oc_i,
    output logic          oc_any_o
);
    logic [NB-1:0] lat_q;

    for (genvar b = 0; b < NB; b++) begin : g_br
        // Capture this bridge's event; sleep or reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n || !awake_i) lat_q[b] <= 1'b0;
            else if (oc_i[b])       lat_q[b] <= 1'b1;
        end
    end

    assign oc_any_o = |lat_q;

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_i && |oc_i) |=> oc_any_o);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_i && oc_any_o) |=> oc_any_o);
    a_r5_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |=> !oc_any_o);
endmodule

// File: rtl/mdrv_wake_timer.sv
// Counts settling cycles after sleep is released and flags readiness.
// Assumes sleep_n is already synchronous to clk.
module mdrv_wake_timer #(
    parameter int WAKE_CYC = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake_i,
    output logic ready_o
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

    logic [CW-1:0] cnt_q;

    // Count up while awake, saturate at the limit, restart when asleep.
    always_ff @(posedge clk) begin
        if (!rst_n || !awake_i)  cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign ready_o = (cnt_q == LIMIT);

    a_r3_sleep_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |=> !ready_o);
    a_r2_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && awake_i) |=> ready_o);
endmodule

// File: rtl/mdrv_fault_sup.sv
// Protection supervisor for a two-bridge motor driver: wake settling,
// latched overcurrent, thermal and undervoltage hysteresis, fault output.
// Assumes every input is synchronous to clk.
module mdrv_fault_sup
    import mdrv_pkg::*;
#(
    parameter int WAKE_CYC = 150000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_n,
    input  logic                  ot_set,
    input  logic                  ot_rel,
    input  logic                  uv_set,
    input  logic                  uv_rel,
    input  logic [NUM_BRIDGE-1:0] oc_flag,
    input  logic [NUM_DIR-1:0]    dir_in,
    output logic                  bridge_en,
    output logic                  wake_ready,
    output logic                  fault_n
);
    mdrv_hold_t hold;
    logic       ready;

    mdrv_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .awake_i(sleep_n), .ready_o(ready));

    mdrv_oc_latch #(.NB(NUM_BRIDGE)) u_oc (
        .clk(clk), .rst_n(rst_n), .awake_i(sleep_n),
        .oc_i(oc_flag), .oc_any_o(hold.oc));

    mdrv_hyst_flag u_ot (
        .clk(clk), .rst_n(rst_n), .set_i(ot_set), .rel_i(ot_rel),
        .held_o(hold.ot));

    mdrv_hyst_flag u_uv (
        .clk(clk), .rst_n(rst_n), .set_i(uv_set), .rel_i(uv_rel),
        .held_o(hold.uv));

    // Combine readiness, held faults and idle direction inputs.
    always_comb begin
        wake_ready = ready;
        fault_n    = !(hold.ot || hold.oc);
        bridge_en  = ready && (hold == '0) && (dir_in != '0);
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!wake_ready && !bridge_en && fault_n));
    a_r9_en_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_en |-> (wake_ready && fault_n));
    a_r7_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        uv_set |=> !bridge_en);
    a_r8_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in == '0) |-> !bridge_en);
endmodule

// File: tb/mdrv_fault_sup_bench.sv
// Scoreboard bench: the driver applies a cycle of stimulus and queues the
// expected outputs; the monitor compares them after the following edge.
module mdrv_fault_sup_bench;
    localparam int W  = 8;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0, sleep_n = 1'b0;
    logic ot_set = 1'b0, ot_rel = 1'b0, uv_set = 1'b0, uv_rel = 1'b0;
    logic [NB-1:0] oc_flag = '0;
    logic [3:0]    dir_in  = '0;
    logic bridge_en, wake_ready, fault_n;

    always #5 clk = ~clk;

    mdrv_fault_sup #(.WAKE_CYC(W)) u_mdrv_fault_sup (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n),
        .ot_set(ot_set), .ot_rel(ot_rel), .uv_set(uv_set), .uv_rel(uv_rel),
        .oc_flag(oc_flag), .dir_in(dir_in),
        .bridge_en(bridge_en), .wake_ready(wake_ready), .fault_n(fault_n));

    typedef struct {
        logic  en;
        logic  rdy;
        logic  fn;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    bit done = 0;

    // Reference state, kept from the requirements.
    int  m_cnt = 0;
    bit  m_ot = 0, m_uv = 0, m_oc = 0;

    // Apply one cycle of inputs and queue what the requirements predict.
    task automatic drive(input logic r, input logic s, input logic [NB-1:0] oc,
                         input logic os, input logic orl, input logic us,
                         input logic url, input logic [3:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r; sleep_n = s; oc_flag = oc; ot_set = os; ot_rel = orl;
        uv_set = us; uv_rel = url; dir_in = d;
        if (!r) begin
            m_cnt = 0; m_ot = 0; m_uv = 0; m_oc = 0;
        end else begin
            if (!s) begin m_cnt = 0; m_oc = 0; end
            else begin
                if (m_cnt < W) m_cnt++;
                if (oc != 0) m_oc = 1;
            end
            if (os) m_ot = 1; else if (orl) m_ot = 0;
            if (us) m_uv = 1; else if (url) m_uv = 0;
        end
        e.rdy = (m_cnt == W);
        e.fn  = !(m_ot || m_oc);
        e.en  = e.rdy && !m_ot && !m_oc && !m_uv && (d != 0);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Pop and compare once the edge after each drive has settled.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (bridge_en !== e.en || wake_ready !== e.rdy || fault_n !== e.fn) begin
                    fails++;
                    $display("FAIL %s: en/rdy/fault_n got %b%b%b expected %b%b%b",
                             e.tag, bridge_en, wake_ready, fault_n, e.en, e.rdy, e.fn);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) drive(0, 1, '0, 0, 0, 0, 0, 4'b0001, "R1 reset");
        // R2 wake window, every cycle checked; R9 enable once ready
        repeat (W + 2) drive(1, 1, '0, 0, 0, 0, 0, 4'b0001, "R2 R9 wake");
        // R8 idle direction inputs
        repeat (2) drive(1, 1, '0, 0, 0, 0, 0, 4'b0000, "R8 idle");
        drive(1, 1, '0, 0, 0, 0, 0, 4'b0100, "R8 resume");
        // R4 one-cycle overcurrent on bridge 1, R5 hold
        drive(1, 1, 2'b10, 0, 0, 0, 0, 4'b0100, "R4 oc pulse");
        repeat (3) drive(1, 1, '0, 0, 0, 0, 0, 4'b0100, "R5 oc held");
        // R3 sleep clears readiness and the latch; R10 oc ignored asleep
        drive(1, 0, '0, 0, 0, 0, 0, 4'b0100, "R3 R5 sleep");
        drive(1, 0, 2'b11, 0, 0, 0, 0, 4'b0100, "R10 oc asleep");
        repeat (W + 1) drive(1, 1, '0, 0, 0, 0, 0, 4'b0100, "R10 R2 rewake");
        // R2 restart: sleep in the middle of the window
        repeat (3) drive(1, 1, '0, 0, 0, 0, 0, 4'b0010, "R2 partial");
        drive(1, 0, '0, 0, 0, 0, 0, 4'b0010, "R2 sleep mid");
        repeat (W + 1) drive(1, 1, '0, 0, 0, 0, 0, 4'b0010, "R2 restart");
        // R6 thermal set, hold, both flags, release
        drive(1, 1, '0, 1, 0, 0, 0, 4'b0010, "R6 ot set");
        repeat (2) drive(1, 1, '0, 0, 0, 0, 0, 4'b0010, "R6 ot held");
        drive(1, 1, '0, 1, 1, 0, 0, 4'b0010, "R6 set wins");
        drive(1, 1, '0, 0, 1, 0, 0, 4'b0010, "R6 release");
        // R7 undervoltage
        drive(1, 1, '0, 0, 0, 1, 0, 4'b1000, "R7 uv set");
        drive(1, 1, '0, 0, 0, 1, 1, 4'b1000, "R7 set wins");
        drive(1, 1, '0, 0, 0, 0, 0, 4'b1000, "R7 uv held");
        drive(1, 1, '0, 0, 0, 0, 1, 4'b1000, "R7 release");
        // R5 reset also clears the latch, bridge 0 this time
        drive(1, 1, 2'b01, 0, 0, 0, 0, 4'b1000, "R4 oc br0");
        drive(0, 1, '0, 0, 0, 0, 0, 4'b1000, "R5 R1 reset clears");
        repeat (W + 1) drive(1, 1, '0, 0, 0, 0, 0, 4'b1000, "R5 R9 after reset");
        @(negedge clk);
        @(posedge clk);
        #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule